// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block sits between a simple request port and the command pins of a four-bank synchronous DRAM. Each request carries a flat address, a direction, a burst-length code and an auto-precharge flag. The block opens the row with an ACTIVE command and waits a parameterised row-to-column delay. It then issues READ or WRITE with the start column and produces the column address of every beat of the burst. A burst can be cut short with a burst-terminate command. Read-data timing is a fixed CAS-latency delay line.

The flat request address is split as bank = `req_addr[22:21]`, row = `req_addr[20:9]` and column = `req_addr[8:0]`. All command, address and beat outputs come from registers that update on the rising clock edge. While a sequence is in progress, `req_ready` is low and any request is ignored. This includes the self-timed precharge wait that follows an auto-precharge burst.

Top module: `sdram_burst_seq`

## Requirements
- R1: A request accepted at a rising edge (`req_valid` and `req_ready` both high) makes the next output cycle an ACTIVE command. The command pins {cs_n,ras_n,cas_n,we_n} are 0011, `sd_ba` equals `req_addr[22:21]` and `sd_a` equals `req_addr[20:9]`.
- R2: Exactly TRCD cycles after ACTIVE, the block issues READ (0101) or WRITE (0100) according to `req_write`. `sd_ba` holds the bank, `sd_a[8:0]` holds the start column and `sd_a[10]` holds the effective auto-precharge flag. All other `sd_a` bits are 0.
- R3: During reset, the command pins are 1111 (command inhibit) and `req_ready` is low. After reset, and in every cycle with no command to issue, the pins are NOP (0111) with `sd_ba` and `sd_a` at 0. `req_ready` is high whenever the block is idle.
- R4: `beat_valid` is high for the burst's beats, starting in the READ/WRITE cycle. The length code in `req_len` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Beat k has column base + ((start + k) mod BL), where base is the start column with its low log2(BL) bits cleared. `beat_col` is defined only while `beat_valid` is high.
- R5: Length codes 4 to 7 select a full-page burst. Its beat k has column (start + k) mod 512, and it runs until terminated. For a full page, `req_ap` is ignored: `sd_a[10]` is 0 and no precharge wait follows.
- R6: Suppose `req_term` is high at an edge while a beat is shown, that beat is not the last one, and the burst has no auto precharge. Then the next cycle carries BURST TERMINATE (0110), `beat_valid` is low and `req_ready` is high. In every other case `req_term` has no effect.
- R7: After an auto-precharge burst ends, `req_ready` stays low for TRP more cycles. Only NOP is issued during those cycles.
- R8: `req_ready` is low from the ACTIVE cycle until the sequence ends. Requests presented in that time are ignored.
- R9: `rd_valid` is high exactly CAS_LAT cycles after each read beat, and never for write beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Bank, row, column |
| req_len | input | 3 | Burst length code |
| req_ap | input | 1 | Auto precharge at burst end |
| req_term | input | 1 | Cut the running burst short |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column address |
| beat_valid | output | 1 | A data beat is in this cycle |
| beat_col | output | 9 | Column of the current beat |
| rd_valid | output | 1 | Read data due on the bus |

## Verification
Two events can land on the same edge. A terminate request can coincide with the burst's final beat, and the natural end of a burst can coincide with the start of a precharge wait. The bench raises `req_term` on the last beat of a four-beat burst and expects the full burst with no BURST TERMINATE. It also raises `req_term` inside an auto-precharge burst and expects every beat to follow, then TRP busy cycles. A behavioural model fills per-cycle expectations for command, bank, address, beats, ready and read-valid, and these are compared on every clock. Back-to-back requests also make the trailing read-valid pulses of one burst overlap the ACTIVE of the next.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_INH = 4'b1111;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_BST = 4'b0110;

  typedef enum logic [1:0] {S_IDLE, S_RCD, S_BURST, S_PRE} seq_st_t;

  function automatic logic is_full(input logic [2:0] code);
    return code[2];
  endfunction

  // beats minus one for fixed lengths
  function automatic logic [2:0] beats_m1(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd1;
      3'd2:    return 3'd3;
      3'd3:    return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  // wrap mask of the column counter, full page wraps over 9 bits
  function automatic logic [8:0] blk_mask(input logic [2:0] code);
    if (code[2]) return 9'h1FF;
    return {6'd0, beats_m1(code)};
  endfunction
endpackage

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [2:0]       len_code,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    mask = COL_W'(blk_mask(len_code));
    if (is_full(len_code)) mask = '1;
    sum  = start_col + beat_idx;
    col  = (start_col & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[DEPTH-1];
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int AP_BIT  = 10,
  parameter int TRCD    = 2,
  parameter int TRP     = 2,
  parameter int CAS_LAT = 2,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic              req_ap,
  input  logic              req_term,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic              beat_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic              rd_valid
);
  localparam int CNT_MAX = (TRCD > TRP) ? TRCD : TRP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_st_t           st;
  logic [3:0]        cmd_q;
  logic [BANK_W-1:0] ba_q, bank_q;
  logic [ROW_W-1:0]  a_q, rw_addr;
  logic [COL_W-1:0]  start_q, idx_q, idx_sel, col_out, col_q;
  logic [2:0]        len_q, rem_q;
  logic              wr_q, ap_q, full_q, bv_q;
  logic [CNT_W-1:0]  cnt_q;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba      = ba_q;
  assign sd_a       = a_q;
  assign beat_valid = bv_q;
  assign beat_col   = col_q;
  assign req_ready  = (st == S_IDLE) && !rst;
  assign full_q     = is_full(len_q);
  assign idx_sel    = (st == S_RCD) ? '0 : idx_q;

  sdram_col_gen #(.COL_W(COL_W)) col_i (
    .start_col(start_q), .beat_idx(idx_sel), .len_code(len_q), .col(col_out)
  );

  sdram_lat_pipe #(.DEPTH(CAS_LAT)) lat_i (
    .clk(clk), .rst(rst), .din(bv_q && !wr_q), .dout(rd_valid)
  );

  always_comb begin
    rw_addr = '0;
    rw_addr[COL_W-1:0] = col_out;
    rw_addr[AP_BIT]    = ap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  cmd_q <= CMD_INH;  ba_q <= '0;  a_q <= '0;
      bv_q <= 1'b0;  col_q <= '0;  cnt_q <= '0;  idx_q <= '0;  rem_q <= '0;
      bank_q <= '0;  start_q <= '0;  len_q <= '0;  wr_q <= 1'b0;  ap_q <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      ba_q  <= '0;
      a_q   <= '0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            bank_q  <= req_addr[ADDR_W-1 -: BANK_W];
            start_q <= req_addr[COL_W-1:0];
            len_q   <= req_len;
            wr_q    <= req_write;
            ap_q    <= req_ap && !is_full(req_len);
            cmd_q   <= CMD_ACT;
            ba_q    <= req_addr[ADDR_W-1 -: BANK_W];
            a_q     <= req_addr[COL_W +: ROW_W];
            cnt_q   <= CNT_W'(TRCD - 1);
            st      <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt_q == '0) begin
            cmd_q <= wr_q ? CMD_WR : CMD_RD;
            ba_q  <= bank_q;
            a_q   <= rw_addr;
            bv_q  <= 1'b1;
            col_q <= col_out;
            idx_q <= COL_W'(1);
            rem_q <= beats_m1(len_q);
            st    <= S_BURST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_BURST: begin
          if (!full_q && rem_q == '0) begin
            bv_q <= 1'b0;
            if (ap_q) begin
              cnt_q <= CNT_W'(TRP - 1);
              st    <= S_PRE;
            end else begin
              st <= S_IDLE;
            end
          end else if (req_term && !ap_q) begin
            cmd_q <= CMD_BST;
            bv_q  <= 1'b0;
            st    <= S_IDLE;
          end else begin
            bv_q  <= 1'b1;
            col_q <= col_out;
            idx_q <= idx_q + 1'b1;
            if (!full_q) rem_q <= rem_q - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt_q == '0) st <= S_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // cycles since the last ACTIVE, saturating; used only by the checks
  logic [7:0] since_act;
  always_ff @(posedge clk) begin
    if (rst)                   since_act <= 8'hFF;
    else if (cmd_q == CMD_ACT) since_act <= 8'd1;
    else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
  end

  // R2: column command lands exactly TRCD cycles after ACTIVE
  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> since_act == 8'(TRCD));

  // R6: a terminate only follows a shown beat
  p_bst_after_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_BST) |-> $past(bv_q));

  // R8: never ready while a beat is on
  p_busy_in_burst_r8: assert property (@(posedge clk) disable iff (rst)
    bv_q |-> !req_ready);

  // R4: consecutive beats of a fixed burst stay in one aligned block
  p_block_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (bv_q && $past(bv_q) && !full_q) |->
      (((col_q ^ $past(col_q)) & ~COL_W'(blk_mask(len_q))) == '0));

  // R7: the precharge wait keeps the port busy after the last beat
  p_pre_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(bv_q) && ap_q) |-> !req_ready);
endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
  localparam int TRCD = 2;
  localparam int TRP  = 2;
  localparam int CL   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0, req_term = 1'b0;
  logic [22:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic        req_ready, cs_n, ras_n, cas_n, we_n, beat_valid, rd_valid;
  logic [1:0]  ba;
  logic [11:0] sa;
  logic [8:0]  beat_col;

  always #4 clk = ~clk;

  sdram_burst_seq #(.TRCD(TRCD), .TRP(TRP), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_ap(req_ap), .req_term(req_term), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_a(sa),
    .beat_valid(beat_valid), .beat_col(beat_col), .rd_valid(rd_valid)
  );

  int cyc = 0;
  int checks = 0, fails = 0;
  bit chk_on = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // expectation tables keyed by output-cycle index; absent entry = idle
  logic [3:0]  e_cmd [int];
  logic [1:0]  e_ba  [int];
  logic [11:0] e_a   [int];
  logic        e_bv  [int];
  logic [8:0]  e_col [int];
  logic        e_rdy [int];
  bit          e_rdv [int];
  string       e_tag [int];

  always @(negedge clk) begin
    if (chk_on) begin
      logic [3:0] xc; logic [1:0] xb; logic [11:0] xa; logic xv, xr, xd;
      logic [8:0] xl; string tg;
      xc = 4'b0111; xb = '0; xa = '0; xv = 0; xr = 1; xl = '0; tg = "R3";
      if (e_cmd.exists(cyc)) begin
        xc = e_cmd[cyc]; xb = e_ba[cyc]; xa = e_a[cyc]; xv = e_bv[cyc];
        xl = e_col[cyc]; xr = e_rdy[cyc]; tg = e_tag[cyc];
      end
      checks++;
      if ({cs_n, ras_n, cas_n, we_n} != xc || ba != xb || sa != xa ||
          beat_valid != xv || req_ready != xr || (xv && beat_col != xl)) begin
        fails++;
        $display("FAIL %s cyc %0d: cmd=%b ba=%0d a=%h bv=%b col=%0d rdy=%b expected cmd=%b ba=%0d a=%h bv=%b col=%0d rdy=%b",
                 tg, cyc, {cs_n, ras_n, cas_n, we_n}, ba, sa, beat_valid, beat_col,
                 req_ready, xc, xb, xa, xv, xl, xr);
      end
      xd = e_rdv.exists(cyc);
      checks++;
      if (rd_valid != xd) begin
        fails++;
        $display("FAIL R9 cyc %0d: rd_valid=%b expected %b", cyc, rd_valid, xd);
      end
    end
  end

  function automatic void put(int c, logic [3:0] cm, logic [1:0] b, logic [11:0] a,
                              logic v, logic [8:0] cl, logic r, string t);
    e_cmd[c] = cm; e_ba[c] = b; e_a[c] = a; e_bv[c] = v; e_col[c] = cl;
    e_rdy[c] = r; e_tag[c] = t;
  endfunction

  // one request; term_k = index of last beat before a terminate, -1 for none
  task automatic run_req(input bit wr, input int bank, input int row, input int col,
                         input int code, input bit ap, input int term_k, input bit junk);
    int a, r, bl, nb, e, done, base;
    bit full, ape, cut;
    full = (code >= 4);
    bl   = full ? 0 : (1 << code);
    ape  = ap && !full;
    cut  = (term_k >= 0) && !ape && (full || term_k < bl - 1);
    nb   = cut ? term_k + 1 : bl;
    a = cyc + 1;
    r = a + TRCD;
    put(a, 4'b0011, bank[1:0], row[11:0], 0, 0, 0, "R1");
    for (int i = 1; i < TRCD; i++) put(a + i, 4'b0111, 0, 0, 0, 0, 0, "R8");
    for (int k = 0; k < nb; k++) begin
      logic [8:0] cc;
      if (full) cc = 9'((col + k) % 512);
      else begin
        base = col - (col % bl);
        cc = 9'(base + ((col % bl) + k) % bl);
      end
      if (k == 0)
        put(r, wr ? 4'b0100 : 4'b0101, bank[1:0], {1'b0, ape, 1'b0, 9'(col)}, 1, cc, 0,
            full ? "R5" : "R2");
      else
        put(r + k, 4'b0111, 0, 0, 1, cc, 0, full ? "R5" : "R4");
      if (!wr) e_rdv[r + k + CL] = 1'b1;
    end
    e = r + nb;
    done = e;
    if (cut) put(e, 4'b0110, 0, 0, 0, 0, 1, "R6");
    else if (ape) begin
      for (int i = 0; i < TRP; i++) put(e + i, 4'b0111, 0, 0, 0, 0, 0, "R7");
      done = e + TRP;
    end
    req_valid = 1; req_write = wr; req_ap = ap; req_len = 3'(code);
    req_addr = {bank[1:0], row[11:0], col[8:0]};
    @(negedge clk);
    if (junk) begin  // R8: requests while busy must be ignored
      req_addr = ~req_addr; req_write = ~wr; req_len = 3'd3;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 0;
    if (term_k >= 0) begin
      while (cyc < r + term_k) @(negedge clk);
      req_term = 1;
      @(negedge clk);
      req_term = 0;
    end
    while (cyc < done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R3 reset state
    if ({cs_n, ras_n, cas_n, we_n} != 4'b1111 || req_ready != 1'b0) begin
      fails++;
      $display("FAIL R3 reset: cmd=%b rdy=%b expected cmd=1111 rdy=0",
               {cs_n, ras_n, cas_n, we_n}, req_ready);
    end
    rst = 0;
    @(negedge clk);
    chk_on = 1;
    @(negedge clk);
    run_req(0, 1, 12'h123, 5,   0, 0, -1, 0);  // R1 R2 R4 BL1 read
    run_req(1, 2, 12'hABC, 3,   1, 1, -1, 0);  // R7 BL2 write with precharge
    run_req(0, 3, 12'h001, 6,   2, 0, -1, 1);  // R4 R8 wrap 6,7,4,5 with junk
    run_req(1, 0, 12'hFFF, 13,  3, 0, -1, 0);  // R4 BL8 write back-to-back
    run_req(0, 1, 12'h555, 20,  3, 1, 2, 0);   // R6 term ignored with precharge
    run_req(0, 2, 12'h2AA, 9,   2, 0, 3, 0);   // R6 term on final beat ignored
    run_req(0, 3, 12'h777, 33,  3, 0, 2, 1);   // R6 terminate BL8 after 3 beats
    repeat (3) @(negedge clk);
    run_req(0, 0, 12'h010, 510, 4, 1, 5, 0);   // R5 full page, ap ignored, wrap
    run_req(1, 1, 12'h020, 0,   7, 0, 515, 0); // R5 full page write past 512
    run_req(0, 2, 12'h030, 511, 1, 1, -1, 0);  // R4 R7 BL2 at column 511
    repeat (6) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule